// File: doc/BRIEF.md
# Angle-to-Quadrature Encoder Emulator

This block turns a stream of absolute shaft-angle words into the signals of an incremental rotary encoder: two quadrature lines, a once-per-turn marker and a direction flag. Each clock it compares the incoming angle, truncated to the selected resolution, against an internally tracked count. It then moves that count one step toward the angle, so the quadrature lines never skip a state. A validity flag from the fault monitor freezes the outputs while the angle cannot be trusted. When the flag returns, the emulator catches up one step per clock.

The angle word is MSB-aligned and `ANGLE_W` bits wide. A two-bit resolution code selects how many of its upper bits count. The lower bits are ignored, so one count step is one LSB of the chosen resolution. The outputs are registered and run freely with no handshake.

Top module: `qenc_emulator`

## Requirements
- R1: While reset is high, the outputs settle one clock later to enc_a_o=0, enc_b_o=0, marker_o=1 and dir_o=1. The tracked count is zero.
- R2: The state order is (enc_a_o, enc_b_o) = 00, 01, 11, 10, then back to 00. It corresponds to the low two bits of the tracked count: enc_a_o = bit1 and enc_b_o = bit1 XOR bit0. A one-count increase moves one state forward and sets dir_o=1.
- R3: A one-count decrease moves the quadrature state one step backward in that order and sets dir_o=0.
- R4: marker_o is high exactly while the tracked count equals zero.
- R5: While valid_i is low, enc_a_o, enc_b_o, marker_o and dir_o keep their values whatever angle_i does.
- R6: When the target differs from the tracked count by several counts, the count moves exactly one count per clock until it is equal. The outputs reflect each step at the clock edge where it is taken.
- R7: res_sel_i values 0, 1, 2 and 3 select ANGLE_W-6, ANGLE_W-4, ANGLE_W-2 and ANGLE_W bits, taken from the top of angle_i. Bits below the selected resolution have no effect on the outputs.
- R8: The step direction follows the shorter way around the circle, modulo 2^resolution, so a path across zero wraps through the marker. A difference of exactly half a turn steps backward.
- R9: dir_o changes only when a step is taken. Otherwise it keeps the direction of the last step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| angle_i | input | ANGLE_W | Absolute angle, MSB-aligned, full turn = 2^ANGLE_W |
| res_sel_i | input | 2 | Resolution code (see R7) |
| valid_i | input | 1 | Angle trustworthy; low freezes the outputs |
| enc_a_o | output | 1 | Quadrature line A |
| enc_b_o | output | 1 | Quadrature line B |
| marker_o | output | 1 | Once-per-turn marker, high at count zero |
| dir_o | output | 1 | High after an increasing step, low after a decreasing one |

## Verification
The bench builds the block with ANGLE_W=8, so the four resolution codes give 2, 4, 6 and 8 bits. A full revolution at every code then takes at most 256 steps. Each count is visited going up and going down at every resolution, which exercises every quadrature transition and every marker pulse. The 6-bit setting is used for multi-count catch-up, a validity drop in the middle of a catch-up, the exact half-turn tie and a shortest-path wrap through zero. The 4-bit setting shows that the bits below the resolution are inert.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Spread in bits between the finest and the coarsest resolution code.
    localparam int RES_SPAN = 6;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    // Count phase (low two bits) to quadrature lines.
    function automatic quad_t quad_of(input logic [1:0] ph);
        quad_t q;
        q.a = ph[1];
        q.b = ph[1] ^ ph[0];
        return q;
    endfunction

    // Quadrature lines back to count phase.
    function automatic logic [1:0] phase_of(input quad_t q);
        return {q.a, q.a ^ q.b};
    endfunction

endpackage

// File: rtl/qenc_tracker.sv
module qenc_tracker #(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic [2:0]         shift_i,
    output logic [ANGLE_W-1:0] trk_nxt_o,
    output logic               dir_o
);
    logic [ANGLE_W-1:0] trk_q, trk_nxt;
    logic [ANGLE_W-1:0] mask, step, tgt, cur, diff;
    logic               dir_q, dir_nxt;

    assign mask = {ANGLE_W{1'b1}} << shift_i;
    assign step = {{(ANGLE_W-1){1'b0}}, 1'b1} << shift_i;
    assign tgt  = angle_i & mask;
    assign cur  = trk_q & mask;
    assign diff = tgt - cur;

    always_comb begin
        trk_nxt = trk_q;
        dir_nxt = dir_q;
        if (valid_i) begin
            if (diff == '0) begin
                trk_nxt = cur;
            end else if (!diff[ANGLE_W-1]) begin
                trk_nxt = cur + step;
                dir_nxt = 1'b1;
            end else begin
                trk_nxt = cur - step;
                dir_nxt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
            dir_q <= 1'b1;
        end else begin
            trk_q <= trk_nxt;
            dir_q <= dir_nxt;
        end
    end

    assign trk_nxt_o = rst ? '0 : trk_nxt;
    assign dir_o     = dir_q;

    // R5
    hold_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(trk_q) && $stable(dir_q)));

    // R6
    moves_toward_target_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (diff != '0)) |=> (trk_q != $past(trk_q)));

endmodule

// File: rtl/qenc_phase_out.sv
module qenc_phase_out
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] trk_nxt_i,
    input  logic [2:0]         shift_i,
    input  logic               dir_i,
    output quad_t              quad_o,
    output logic               marker_o
);
    logic [ANGLE_W-1:0] count;
    quad_t              quad_q;
    logic               marker_q;

    assign count = trk_nxt_i >> shift_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            quad_q   <= '0;
            marker_q <= 1'b1;
        end else begin
            quad_q   <= quad_of(count[1:0]);
            marker_q <= (count == '0);
        end
    end

    assign quad_o   = quad_q;
    assign marker_o = marker_q;

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(shift_i) |-> ($countones(quad_q ^ $past(quad_q)) <= 1));

    // R3
    dir_matches_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(shift_i) && (quad_q != $past(quad_q)))
        |-> (dir_i == (phase_of(quad_q) == (phase_of($past(quad_q)) + 2'd1))));

    // R4
    marker_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        marker_q |-> (quad_q == '0));

endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic [1:0]         res_sel_i,
    input  logic               valid_i,
    output logic               enc_a_o,
    output logic               enc_b_o,
    output logic               marker_o,
    output logic               dir_o
);
    localparam logic [2:0] SPAN = 3'(RES_SPAN);

    logic [2:0]         shift;
    logic [ANGLE_W-1:0] trk_nxt;
    quad_t              quad;

    // R7: coarser code drops more low bits
    assign shift = SPAN - {res_sel_i, 1'b0};

    qenc_tracker #(.ANGLE_W(ANGLE_W)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_i),
        .angle_i   (angle_i),
        .shift_i   (shift),
        .trk_nxt_o (trk_nxt),
        .dir_o     (dir_o)
    );

    qenc_phase_out #(.ANGLE_W(ANGLE_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .trk_nxt_i (trk_nxt),
        .shift_i   (shift),
        .dir_i     (dir_o),
        .quad_o    (quad),
        .marker_o  (marker_o)
    );

    assign enc_a_o = quad.a;
    assign enc_b_o = quad.b;

    initial begin
        // R7: lowest resolution must keep at least two bits
        width_floor_chk: assert (ANGLE_W >= RES_SPAN + 2);
    end

endmodule

// File: tb/qenc_emulator_tb.sv
module qenc_emulator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] angle = '0;
    logic [1:0]    res = 2'd0;
    logic          valid = 1'b1;
    logic          ea, eb, mk, dr;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_dir = 1'b1;
    int res_bits = 2;

    qenc_emulator #(.ANGLE_W(AW)) u_dut (
        .clk(clk), .rst(rst), .angle_i(angle), .res_sel_i(res), .valid_i(valid),
        .enc_a_o(ea), .enc_b_o(eb), .marker_o(mk), .dir_o(dr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc(input string tag);
        int nn, tg, df, ph;
        logic [3:0] exp_v, act_v;
        @(posedge clk);
        nn = 1 << res_bits;
        if (rst) begin
            m_cnt = 0;
            m_dir = 1'b1;
        end else if (valid) begin
            tg = int'(angle) >> (AW - res_bits);
            df = (tg - m_cnt + nn) % nn;
            if (df != 0) begin
                if (df < nn / 2) begin
                    m_cnt = (m_cnt + 1) % nn;
                    m_dir = 1'b1;
                end else begin
                    m_cnt = (m_cnt + nn - 1) % nn;
                    m_dir = 1'b0;
                end
            end
        end
        #1;
        ph = m_cnt % 4;
        exp_v = {(ph >= 2), (ph == 1 || ph == 2), (m_cnt == 0), m_dir};
        act_v = {ea, eb, mk, dr};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s res=%0d cnt=%0d actual ABMD=%b expected ABMD=%b",
                     tag, res_bits, m_cnt, act_v, exp_v);
        end
    endtask

    task automatic start(input int code);
        res = 2'(code);
        res_bits = AW - 6 + 2 * code;
        rst = 1'b1;
        angle = '0;
        valid = 1'b1;
        repeat (3) cyc("R1 reset");
        rst = 1'b0;
    endtask

    function automatic logic [AW-1:0] at(input int c);
        return AW'(c << (AW - res_bits));
    endfunction

    initial begin
        for (int r = 0; r < 4; r++) begin
            int nn;
            start(r);
            nn = 1 << res_bits;
            for (int i = 1; i <= nn; i++) begin
                angle = at(i % nn);
                cyc("R2 R4 R7 up");
            end
            for (int i = nn - 1; i >= 0; i--) begin
                angle = at(i);
                cyc("R3 R4 down");
            end
        end

        // sub-resolution bits ignored at 4 bits
        start(1);
        angle = at(3);
        repeat (4) cyc("R6 R7");
        angle = at(3) | 8'h0F;
        repeat (3) cyc("R7 low bits");
        angle = at(3) | 8'h01;
        repeat (2) cyc("R7 low bits");

        // 6-bit: catch-up, invalid hold, half turn, wrap
        start(2);
        angle = at(5);
        repeat (2) cyc("R6 catch-up");
        valid = 1'b0;
        angle = at(20);
        repeat (3) cyc("R5 R9 hold");
        valid = 1'b1;
        repeat (20) cyc("R6 R9 resume");
        angle = at(52);
        repeat (35) cyc("R8 half turn");
        angle = at(2);
        repeat (16) cyc("R8 wrap");
        repeat (3) cyc("R9 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule